// File: doc/BRIEF.md
# Double-Buffered Audio DMA Requester

This block feeds an audio output path with sample data from memory. Software describes each transfer with a byte address and a byte length. It can queue two transfers: one active and one waiting. For the active transfer, the block issues memory read requests of one 8-byte beat at a time. The address steps up by 8 and the remaining length drops by 8 at every accepted request. When the active transfer runs out, a queued transfer takes its place.

An interrupt is raised as the final beat of a transfer is accepted. This tells software early that a slot has freed, so it can queue the next transfer without a gap. Software reads back the remaining length and a status word. Software can stop new requests with an enable bit. Programming a zero bit-rate setting acts as a soft reset that discards all queued work.

The register port is a single-cycle write strobe with a 3-bit select, and a combinational read with a 1-bit select. The memory side is a valid/acknowledge handshake with one request in flight. A space flag from the downstream sample buffer also gates it.

Top module: `aidma_requester`

## Requirements
- R1: After reset, no request is raised, the interrupt is low, and both the length read (select 0) and the status read (select 1) return zero. The enable and bit-rate settings are zero.
- R2: A write to select 0 captures bits [23:0] as the staged address with bits [2:0] forced to zero. A write to select 1 takes bits [17:0] as a byte length with bits [2:0] forced to zero. A length that is then zero is ignored.
- R3: A length write commits the most recently staged address with that length. It goes to the active slot if the active length is zero and the queue is empty. Otherwise it goes to the queue if the queue is empty. Otherwise it is ignored.
- R4: While enabled with a nonzero active length, requests are issued at ascending 8-byte aligned addresses, starting at the committed address. A request is accepted on an edge where valid and acknowledge are both high, and each acceptance lowers the active length by 8.
- R5: A raised request holds its address stable until acknowledged. Only one is outstanding at a time, and valid is low in the cycle after an acceptance. A new request is raised only if the buffer-space input was high in the preceding cycle.
- R6: The interrupt goes high on the edge that accepts the request which takes the active length to zero. Any write to select 3 clears it, unless the same edge sets it.
- R7: When the active length is zero and the queue is occupied, the queued descriptor becomes active on the next edge and FULL clears. Its beats follow those of the earlier transfer.
- R8: Read select 0 returns the active remaining length in bits [17:0], never the queued one. In the read select 1 word, bit 31 and bit 0 are FULL (queue occupied) and bit 30 is BUSY (active length nonzero). Bit 27 is enabled with nonzero length, bit 26 is a request outstanding, bit 25 is enable, and all other bits are zero.
- R9: Bit 0 of a write to select 2 is the DMA enable. While it is zero, no new request is raised and the remaining length is kept.
- R10: When bits [3:0] of the select 4 setting are zero, several things happen: the active length is zero, the queue is emptied, an outstanding request is withdrawn at the writing edge, and length writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Write select: 0 address, 1 length, 2 enable, 3 interrupt clear, 4 bit rate |
| regWrData | input | 32 | Write data |
| regRdSel | input | 1 | Read select: 0 length, 1 status |
| regRdData | output | 32 | Read data |
| memReqValid | output | 1 | Memory read request valid |
| memReqAddr | output | 24 | Byte address of the 8-byte beat |
| memReqAck | input | 1 | Request accepted |
| bufSpace | input | 1 | Downstream sample buffer can take a beat |
| irq | output | 1 | Transfer-ending interrupt |

## Verification
The engine is tried with a single transfer whose address and length carry stray low bits, which separates correct alignment and beat counting from off-by-one lengths. It is also tried with two back-to-back transfers plus a third write that must be dropped, which shows queue ordering, promotion and the overflow rule. A transfer held off first by a missing buffer space and then by a cleared enable shows that both gates stop new requests without losing the remaining length. A soft reset applied with a full queue, and again with a request stuck unacknowledged, separates flushing from mere pausing.

// File: rtl/aidma_pkg.sv
package aidma_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR   = 3'd0,
    SEL_LEN    = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_RATE   = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;
    logic loadActive;
    logic loadQueue;
    logic step;
    logic promote;
    logic flush;
  } dpCmd_t;

endpackage

// File: rtl/aidma_datapath.sv
module aidma_datapath
  import aidma_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [31:0]   wrData,
  output logic [AW-1:0] activeAddr,
  output logic [LW-1:0] activeLen,
  output logic          full,
  output logic          lenZero,
  output logic          lastBeat
);
  localparam int ALIGN = $clog2(BEAT_BYTES);

  logic [AW-1:0] stagedAddr;
  logic [AW-1:0] queuedAddr;
  logic [LW-1:0] queuedLen;
  logic [AW-1:0] addrIn;
  logic [LW-1:0] lenIn;

  assign addrIn   = {wrData[AW-1:ALIGN], {ALIGN{1'b0}}};
  assign lenIn    = {wrData[LW-1:ALIGN], {ALIGN{1'b0}}};
  assign lenZero  = (activeLen == '0);
  assign lastBeat = (activeLen == LW'(BEAT_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedAddr <= '0;
    end else if (cmd.capAddr) begin
      stagedAddr <= addrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAddr <= '0;
      activeLen  <= '0;
      queuedAddr <= '0;
      queuedLen  <= '0;
      full       <= 1'b0;
    end else if (cmd.flush) begin
      activeLen <= '0;
      queuedLen <= '0;
      full      <= 1'b0;
    end else begin
      if (cmd.loadActive) begin
        activeAddr <= stagedAddr;
        activeLen  <= lenIn;
      end else if (cmd.promote) begin
        activeAddr <= queuedAddr;
        activeLen  <= queuedLen;
        full       <= 1'b0;
      end else if (cmd.step) begin
        activeAddr <= activeAddr + AW'(BEAT_BYTES);
        activeLen  <= activeLen - LW'(BEAT_BYTES);
      end
      if (cmd.loadQueue) begin
        queuedAddr <= stagedAddr;
        queuedLen  <= lenIn;
        full       <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/aidma_control.sv
module aidma_control
  import aidma_pkg::*;
#(
  parameter int LW = 18,
  parameter int BEAT_BYTES = 8,
  parameter int RATE_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regWrSel,
  input  logic [31:0] regWrData,
  input  logic        memReqAck,
  input  logic        bufSpace,
  input  logic        lenZero,
  input  logic        lastBeat,
  input  logic        full,
  output dpCmd_t      cmd,
  output logic        reqValid,
  output logic        dmaEn,
  output logic        irq
);
  localparam int ALIGN = $clog2(BEAT_BYTES);

  logic [RATE_W-1:0] bitRate;
  logic rateOn;
  logic wrLen;
  logic lenNonZero;
  logic softWr;
  logic accept;

  assign rateOn     = (bitRate != '0);
  assign lenNonZero = |regWrData[LW-1:ALIGN];
  assign wrLen      = regWrEn && (regWrSel == SEL_LEN) && rateOn && lenNonZero;
  assign softWr     = regWrEn && (regWrSel == SEL_RATE) && (regWrData[RATE_W-1:0] == '0);
  assign accept     = reqValid && memReqAck;

  always_comb begin
    cmd            = '0;
    cmd.capAddr    = regWrEn && (regWrSel == SEL_ADDR);
    cmd.loadActive = wrLen && lenZero && !full;
    cmd.loadQueue  = wrLen && !lenZero && !full;
    cmd.step       = accept;
    cmd.promote    = rateOn && lenZero && full;
    cmd.flush      = !rateOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitRate <= '0;
      dmaEn   <= 1'b0;
    end else if (regWrEn) begin
      if (regWrSel == SEL_RATE) bitRate <= regWrData[RATE_W-1:0];
      if (regWrSel == SEL_CTRL) dmaEn <= regWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
    end else if (softWr || !rateOn) begin
      reqValid <= 1'b0;
    end else if (reqValid) begin
      reqValid <= !memReqAck;
    end else begin
      reqValid <= dmaEn && !lenZero && bufSpace;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (accept && lastBeat) begin
      irq <= 1'b1;
    end else if (regWrEn && (regWrSel == SEL_STATUS)) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/aidma_requester.sv
module aidma_requester
  import aidma_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int BEAT_BYTES = 8,
  parameter int RATE_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [2:0]    regWrSel,
  input  logic [31:0]   regWrData,
  input  logic          regRdSel,
  output logic [31:0]   regRdData,
  output logic          memReqValid,
  output logic [AW-1:0] memReqAddr,
  input  logic          memReqAck,
  input  logic          bufSpace,
  output logic          irq
);
  dpCmd_t        cmd;
  logic [LW-1:0] activeLen;
  logic          full;
  logic          lenZero;
  logic          lastBeat;
  logic          dmaEn;
  logic [31:0]   statusWord;

  aidma_control #(.LW(LW), .BEAT_BYTES(BEAT_BYTES), .RATE_W(RATE_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memReqAck(memReqAck), .bufSpace(bufSpace),
    .lenZero(lenZero), .lastBeat(lastBeat), .full(full),
    .cmd(cmd), .reqValid(memReqValid), .dmaEn(dmaEn), .irq(irq)
  );

  aidma_datapath #(.AW(AW), .LW(LW), .BEAT_BYTES(BEAT_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData),
    .activeAddr(memReqAddr), .activeLen(activeLen), .full(full),
    .lenZero(lenZero), .lastBeat(lastBeat)
  );

  always_comb begin
    statusWord     = '0;
    statusWord[31] = full;
    statusWord[30] = !lenZero;
    statusWord[27] = dmaEn && !lenZero;
    statusWord[26] = memReqValid;
    statusWord[25] = dmaEn;
    statusWord[0]  = full;
  end

  assign regRdData = regRdSel ? statusWord : {{(32-LW){1'b0}}, activeLen};

endmodule

// File: rtl/aidma_checker.sv
module aidma_checker #(
  parameter int AW = 24,
  parameter int BEAT_BYTES = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic [2:0]    regWrSel,
  input logic [31:0]   regWrData,
  input logic          memReqValid,
  input logic [AW-1:0] memReqAddr,
  input logic          memReqAck,
  input logic          bufSpace,
  input logic          irq
);
  localparam int ALIGN = $clog2(BEAT_BYTES);

  logic softWr;
  logic clrWr;
  assign softWr = regWrEn && (regWrSel == 3'd4) && (regWrData[3:0] == 4'd0);
  assign clrWr  = regWrEn && (regWrSel == 3'd3);

  // R5: request held with stable address until acknowledged
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqAck && !softWr) |=> (memReqValid && $stable(memReqAddr)));

  // R5: one outstanding request
  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqAck) |=> !memReqValid);

  // R5: new request only after buffer space seen
  a_r5_space_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(bufSpace));

  // R4: beat addresses aligned
  a_r4_aligned_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[ALIGN-1:0] == '0));

  // R6: interrupt only rises from an accepted beat
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memReqValid && memReqAck));

  // R6: clear write drops the interrupt
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !(memReqValid && memReqAck)) |=> !irq);

  // R10: soft reset withdraws request
  a_r10_soft_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> !memReqValid);

endmodule

bind aidma_requester aidma_checker #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
  .regWrData(regWrData), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
  .memReqAck(memReqAck), .bufSpace(bufSpace), .irq(irq)
);

// File: tb/aidma_requester_tb_top.sv
module aidma_requester_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        regRdSel = 1'b0;
  logic [31:0] regRdData;
  logic        memReqValid;
  logic [23:0] memReqAddr;
  logic        memReqAck;
  logic        bufSpace = 1'b1;
  logic        irq;
  logic        ackEn = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] logAddr [0:63];
  int logCnt = 0;

  always #10 clk = ~clk;

  assign memReqAck = ackEn & memReqValid;

  aidma_requester dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqAck(memReqAck),
    .bufSpace(bufSpace), .irq(irq)
  );

  always @(negedge clk) begin
    if (rstN && memReqValid && memReqAck) begin
      if (logCnt < 64) logAddr[logCnt] = memReqAddr;
      logCnt = logCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] val);
    regRdSel = sel;
    #1;
    val = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(1'b0, v); check(v == 0, "R1 length", v, 0);
    rd(1'b1, v); check(v == 0, "R1 status", v, 0);
    check(irq == 0 && memReqValid == 0, "R1 outputs", {irq, memReqValid}, 0);
  endtask

  task automatic testNoRate();
    logic [31:0] v;
    wr(3'd0, 32'h100); wr(3'd1, 32);
    rd(1'b0, v); check(v == 0, "R10 length ignored at zero rate", v, 0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    wr(3'd4, 3); wr(3'd2, 1);
    logCnt = 0;
    wr(3'd0, 32'h0000_0107); wr(3'd1, 32'h25);
    idle(20);
    check(logCnt == 4, "R2 beat count", logCnt, 4);
    for (int i = 0; i < 4; i++)
      check(logAddr[i] == 24'h100 + 24'(8 * i), "R4 beat address", logAddr[i], 24'h100 + 24'(8 * i));
    check(irq == 1, "R6 irq on last beat", irq, 1);
    rd(1'b0, v); check(v == 0, "R4 length drained", v, 0);
    wr(3'd3, 0);
    check(irq == 0, "R6 irq cleared", irq, 0);
    logCnt = 0;
    wr(3'd0, 32'h180); wr(3'd1, 7);
    idle(6);
    check(logCnt == 0, "R2 zero length ignored", logCnt, 0);
  endtask

  task automatic testDouble();
    logic [31:0] v;
    wr(3'd2, 0);
    wr(3'd0, 32'h300); wr(3'd1, 16);
    wr(3'd0, 32'h400); wr(3'd1, 24);
    rd(1'b1, v); check(v == 32'hC000_0001, "R8 status full", v, 32'hC000_0001);
    rd(1'b0, v); check(v == 16, "R8 length is active slot", v, 16);
    wr(3'd0, 32'h500); wr(3'd1, 8);
    logCnt = 0;
    wr(3'd2, 1);
    idle(40);
    check(logCnt == 5, "R3 third descriptor dropped", logCnt, 5);
    check(logAddr[0] == 24'h300 && logAddr[1] == 24'h308, "R7 first transfer", logAddr[1], 24'h308);
    check(logAddr[2] == 24'h400 && logAddr[4] == 24'h410, "R7 promoted transfer", logAddr[4], 24'h410);
    rd(1'b1, v); check(v == 32'h0200_0000, "R7 full cleared", v, 32'h0200_0000);
    wr(3'd3, 0);
  endtask

  task automatic testGates();
    logic [31:0] v;
    bufSpace = 1'b0;
    logCnt = 0;
    wr(3'd0, 32'h200); wr(3'd1, 64);
    idle(10);
    check(memReqValid == 0 && logCnt == 0, "R5 no space no request", memReqValid, 0);
    rd(1'b1, v); check(v == 32'h4A00_0000, "R8 status busy", v, 32'h4A00_0000);
    wr(3'd2, 0);
    bufSpace = 1'b1;
    idle(10);
    check(logCnt == 0, "R9 disabled no request", logCnt, 0);
    rd(1'b0, v); check(v == 64, "R9 length kept", v, 64);
    wr(3'd2, 1);
    idle(40);
    check(logCnt == 8, "R4 resumed beats", logCnt, 8);
    check(logAddr[7] == 24'h238, "R4 last address", logAddr[7], 24'h238);
    wr(3'd3, 0);
  endtask

  task automatic testSoft();
    logic [31:0] v;
    wr(3'd2, 0);
    wr(3'd0, 32'h600); wr(3'd1, 40);
    wr(3'd0, 32'h700); wr(3'd1, 8);
    rd(1'b1, v); check(v[31] == 1, "R10 queue loaded before flush", v, 32'h8000_0000);
    wr(3'd4, 0);
    idle(2);
    rd(1'b0, v); check(v == 0, "R10 length flushed", v, 0);
    rd(1'b1, v); check(v == 0, "R10 status flushed", v, 0);
    wr(3'd4, 5); wr(3'd2, 1);
    logCnt = 0;
    idle(20);
    check(logCnt == 0, "R10 no requests after flush", logCnt, 0);
    ackEn = 1'b0;
    wr(3'd0, 32'h800); wr(3'd1, 8);
    idle(5);
    check(memReqValid == 1 && memReqAddr == 24'h800, "R5 held until ack", memReqAddr, 24'h800);
    wr(3'd4, 0);
    check(memReqValid == 0, "R10 request withdrawn", memReqValid, 0);
    ackEn = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testNoRate();
    testSingle();
    testDouble();
    testGates();
    testSoft();
    idle(2);
    finishRun();
  end

endmodule